// File: doc/BRIEF.md
# Saturating Fixed-Point DSP ALU with Sticky Status

This block is the fixed-point arithmetic unit of a DSP datapath. On each cycle where the valid strobe is high it takes two signed two's-complement operands and an opcode, and performs one of four operations: add, subtract, average or compare. It registers the result and a five-bit status word holding zero, negative, carry, overflow and invalid flags. When the saturation mode input is high, an add or subtract that overflows is clamped to the largest or smallest representable value instead of wrapping.

A sticky register keeps a history of selected status bits across operations. Each bit stays set until software-side control logic pulses the sticky-clear strobe. Which status bits are kept is fixed by a parameter mask. By default only overflow and invalid are kept. The saturation hardware can be left out through a parameter, in which case the mode input has no effect.

Top module: `dsp_sat_alu`

## Requirements
- R1: After reset, `result_o`, `status_o` and `sticky_o` are all zero.
- R2: Opcode 2'b00 adds. Without saturation the sum wraps modulo 2^32. The status bit positions are: bit0 zero, bit1 negative, bit2 carry, bit3 overflow, bit4 invalid. Carry is the unsigned carry-out and overflow is signed overflow. For example, -1 + 1 gives 0 with the zero and carry bits set and no overflow.
- R3: Opcode 2'b01 computes A - B. Carry is 1 when there is no unsigned borrow (A >= B unsigned), and overflow flags signed overflow.
- R4: With `sat_en_i` high, an overflowing add or subtract gives 0x7FFFFFFF for a positive overflow and 0x80000000 for a negative one. The overflow bit is still set, and the zero and negative bits describe the clamped result.
- R5: Opcode 2'b10 gives floor((A+B)/2), computed from a 33-bit signed sum. It never sets overflow, and its carry is the unsigned carry-out of A+B.
- R6: Opcode 2'b11 compares. It sets the status from A - B, using the same flag rules as R3, and leaves `result_o` unchanged.
- R7: The invalid bit (bit4) is always 0 for these fixed-point operations.
- R8: When `valid_i` is low, `result_o` and `status_o` keep their values.
- R9: Each valid operation ORs its status bits that are selected by the mask into `sticky_o`. The default mask is 5'b11000 (overflow and invalid). Bits outside the mask never set, and sticky bits that are set stay set while no clear arrives.
- R10: A pulse on `sticky_clr_i` clears `sticky_o` at the next edge. If the same cycle also carries an operation that raises a masked bit, that bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 2 | Opcode: 00 add, 01 sub, 10 average, 11 compare |
| sat_en_i | input | 1 | Saturation mode enable |
| a_i | input | 32 | Operand A (signed) |
| b_i | input | 32 | Operand B (signed) |
| sticky_clr_i | input | 1 | Clears the sticky register |
| result_o | output | 32 | Registered result |
| status_o | output | 5 | Registered status flags of the last operation |
| sticky_o | output | 5 | Accumulated sticky flags |

## Verification
Two events can fall in the same cycle: a sticky clear and an operation whose overflow sets a sticky bit. The bench provokes this by pulsing `sticky_clr_i` during an overflowing add. It expects the overflow bit to survive in `sticky_o`, while unrelated history is cleared. Random traffic also drops the clear strobe in at random alongside random operations, and a reference model judges each case as clear-then-OR.

// File: rtl/dsp_alu_pkg.sv
package dsp_alu_pkg;
   typedef enum logic [1:0] {
      OP_ADD = 2'b00,
      OP_SUB = 2'b01,
      OP_AVG = 2'b10,
      OP_CMP = 2'b11
   } alu_op_e;

   localparam int FLAG_W  = 5;
   localparam int F_ZERO  = 0;
   localparam int F_NEG   = 1;
   localparam int F_CARRY = 2;
   localparam int F_OVF   = 3;
   localparam int F_INV   = 4;
endpackage

// File: rtl/dsp_alu_adder.sv
module dsp_alu_adder #(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   output logic [W-1:0] sum,
   output logic         carry,
   output logic         ovf
);
   logic [W-1:0] b_eff;
   logic [W:0]   wide;

   always_comb begin
      b_eff = sub ? ~b : b;
      wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
      sum   = wide[W-1:0];
      carry = wide[W];
      ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
   end
endmodule

// File: rtl/dsp_alu_avg.sv
module dsp_alu_avg #(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] avg
);
   logic [W:0] wide;

   always_comb begin
      wide = {a[W-1], a} + {b[W-1], b};
      avg  = wide[W:1];
   end
endmodule

// File: rtl/dsp_alu_sat.sv
module dsp_alu_sat #(
   parameter int W           = 32,
   parameter bit SAT_SUPPORT = 1'b1
) (
   input  logic [W-1:0] raw,
   input  logic         ovf,
   input  logic         a_sign,
   input  logic         en,
   output logic [W-1:0] res
);
   localparam logic [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};

   generate
      if (SAT_SUPPORT) begin : g_clamp
         always_comb begin
            if (en && ovf) res = a_sign ? MIN_V : MAX_V;
            else           res = raw;
         end
      end else begin : g_wrap
         logic unused_sat;
         assign unused_sat = ovf ^ a_sign ^ en;
         assign res = raw;
      end
   endgenerate
endmodule

// File: rtl/dsp_alu_sticky.sv
module dsp_alu_sticky #(
   parameter int                FW   = 5,
   parameter logic [FW-1:0]     MASK = '1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          upd,
   input  logic          clr,
   input  logic [FW-1:0] flags,
   output logic [FW-1:0] sticky
);
   logic [FW-1:0] base;
   logic [FW-1:0] set_vec;

   always_comb begin
      base    = clr ? '0 : sticky;
      set_vec = upd ? (flags & MASK) : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) sticky <= '0;
      else        sticky <= base | set_vec;
   end
endmodule

// File: rtl/dsp_sat_alu.sv
module dsp_sat_alu
   import dsp_alu_pkg::*;
#(
   parameter int                 W           = 32,
   parameter bit                 SAT_SUPPORT = 1'b1,
   parameter logic [FLAG_W-1:0]  STICKY_MASK = 5'b11000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_i,
   input  logic [1:0]        op_i,
   input  logic              sat_en_i,
   input  logic [W-1:0]      a_i,
   input  logic [W-1:0]      b_i,
   input  logic              sticky_clr_i,
   output logic [W-1:0]      result_o,
   output logic [FLAG_W-1:0] status_o,
   output logic [FLAG_W-1:0] sticky_o
);
   generate
      if (W < 4) begin : g_bad_width
         $error("dsp_sat_alu: W must be at least 4");
      end
   endgenerate

   alu_op_e          op;
   logic [W-1:0]     sum;
   logic             carry;
   logic             ovf_raw;
   logic [W-1:0]     avg;
   logic [W-1:0]     clamped;
   logic [W-1:0]     next_res;
   logic [FLAG_W-1:0] next_flags;

   assign op = alu_op_e'(op_i);

   dsp_alu_adder #(.W(W)) u_adder (
      .a(a_i), .b(b_i), .sub(op_i[0]),
      .sum(sum), .carry(carry), .ovf(ovf_raw)
   );

   dsp_alu_avg #(.W(W)) u_avg (
      .a(a_i), .b(b_i), .avg(avg)
   );

   dsp_alu_sat #(.W(W), .SAT_SUPPORT(SAT_SUPPORT)) u_sat (
      .raw(sum), .ovf(ovf_raw), .a_sign(a_i[W-1]),
      .en(sat_en_i && !op_i[1]), .res(clamped)
   );

   always_comb begin
      case (op)
         OP_ADD, OP_SUB: next_res = clamped;
         OP_AVG:         next_res = avg;
         default:        next_res = sum;
      endcase
      next_flags          = '0;
      next_flags[F_ZERO]  = (next_res == '0);
      next_flags[F_NEG]   = next_res[W-1];
      next_flags[F_CARRY] = carry;
      next_flags[F_OVF]   = ovf_raw && (op != OP_AVG);
      next_flags[F_INV]   = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result_o <= '0;
         status_o <= '0;
      end else if (valid_i) begin
         status_o <= next_flags;
         if (op != OP_CMP) result_o <= next_res;
      end
   end

   dsp_alu_sticky #(.FW(FLAG_W), .MASK(STICKY_MASK)) u_sticky (
      .clk(clk), .rst_n(rst_n), .upd(valid_i), .clr(sticky_clr_i),
      .flags(next_flags), .sticky(sticky_o)
   );
endmodule

// File: rtl/dsp_sat_alu_chk.sv
module dsp_sat_alu_chk #(
   parameter int         W           = 32,
   parameter logic [4:0] STICKY_MASK = 5'b11000
) (
   input logic         clk,
   input logic         rst_n,
   input logic         valid_i,
   input logic [1:0]   op_i,
   input logic         sat_en_i,
   input logic         sticky_clr_i,
   input logic [W-1:0] result_o,
   input logic [4:0]   status_o,
   input logic [4:0]   sticky_o
);
   localparam logic [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};

   // R7
   inv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !status_o[4]);

   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> ($stable(result_o) && $stable(status_o)));

   // R6
   cmp_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && op_i == 2'b11) |=> $stable(result_o));

   // R5
   avg_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && op_i == 2'b10) |=> !status_o[3]);

   // R4
   sat_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && sat_en_i && !op_i[1]) |=>
         (!status_o[3] || result_o == MAX_V || result_o == MIN_V));

   // R9
   sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sticky_clr_i |=> ((sticky_o & $past(sticky_o)) == $past(sticky_o)));

   // R9
   sticky_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sticky_o & ~STICKY_MASK) == 5'b0);

   // R10
   sticky_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sticky_clr_i && !valid_i) |=> (sticky_o == 5'b0));
endmodule

bind dsp_sat_alu dsp_sat_alu_chk #(.W(W), .STICKY_MASK(STICKY_MASK)) u_chk (
   .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
   .sat_en_i(sat_en_i), .sticky_clr_i(sticky_clr_i),
   .result_o(result_o), .status_o(status_o), .sticky_o(sticky_o)
);

// File: tb/test_dsp_sat_alu.sv
module test_dsp_sat_alu;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid_i = 1'b0;
   logic [1:0]  op_i = 2'b00;
   logic        sat_en_i = 1'b0;
   logic [31:0] a_i = '0;
   logic [31:0] b_i = '0;
   logic        sticky_clr_i = 1'b0;
   logic [31:0] result_o;
   logic [4:0]  status_o;
   logic [4:0]  sticky_o;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   logic [31:0] exp_res = '0;
   logic [4:0]  exp_st  = '0;
   logic [4:0]  exp_stk = '0;

   always #2 clk = ~clk;

   dsp_sat_alu i_dsp_sat_alu (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
      .sat_en_i(sat_en_i), .a_i(a_i), .b_i(b_i), .sticky_clr_i(sticky_clr_i),
      .result_o(result_o), .status_o(status_o), .sticky_o(sticky_o)
   );

   function automatic void model(input logic [1:0] op, input logic [31:0] a,
                                 input logic [31:0] b, input logic sat,
                                 input logic [31:0] prev,
                                 output logic [31:0] r, output logic [4:0] st);
      longint sa = longint'($signed(a));
      longint sb = longint'($signed(b));
      longint s;
      logic [32:0] u;
      logic [31:0] fr;
      logic c, v;
      u = {1'b0, a} + {1'b0, b};
      case (op)
         2'b00:   begin s = sa + sb; c = u[32]; end
         2'b10:   begin s = (sa + sb) >>> 1; c = u[32]; end
         default: begin s = sa - sb; c = (a >= b); end
      endcase
      v  = (op != 2'b10) && (s > 64'sd2147483647 || s < -64'sd2147483648);
      fr = s[31:0];
      if (sat && v && !op[1]) fr = (s > 0) ? 32'h7FFF_FFFF : 32'h8000_0000;
      r  = (op == 2'b11) ? prev : fr;
      st = {1'b0, v, c, fr[31], (fr == 32'h0)};
   endfunction

   task automatic check(input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_op(input logic v, input logic [1:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic sat, input logic clr);
      string tag;
      logic [31:0] r;
      logic [4:0]  st;
      @(negedge clk);
      valid_i = v; op_i = op; a_i = a; b_i = b; sat_en_i = sat; sticky_clr_i = clr;
      model(op, a, b, sat, exp_res, r, st);
      exp_stk = (clr ? 5'b0 : exp_stk) | (v ? (st & 5'b11000) : 5'b0);
      if (v) begin exp_res = r; exp_st = st; end
      if (!v)             tag = "R8";
      else if (op == 3)   tag = "R6";
      else if (op == 2)   tag = "R5";
      else if (sat && st[3]) tag = "R4";
      else if (op == 1)   tag = "R3";
      else                tag = "R2";
      @(negedge clk);
      valid_i = 1'b0; sticky_clr_i = 1'b0;
      check({tag, " result"}, result_o, exp_res);
      check({tag, " status"}, {27'b0, status_o}, {27'b0, exp_st});
      check("R7 invalid bit", {31'b0, status_o[4]}, 32'b0);
      check(clr ? "R10 sticky" : "R9 sticky", {27'b0, sticky_o}, {27'b0, exp_stk});
   endtask

   function automatic logic [31:0] pick();
      case ($urandom_range(0, 6))
         0: return 32'h7FFF_FFFF;
         1: return 32'h8000_0000;
         2: return 32'hFFFF_FFFF;
         3: return 32'h0000_0001;
         4: return 32'h0;
         default: return $urandom();
      endcase
   endfunction

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 result", result_o, 32'h0);
      check("R1 status", {27'b0, status_o}, 32'h0);
      check("R1 sticky", {27'b0, sticky_o}, 32'h0);
      rst_n = 1'b1;

      // R2: -1 + 1 -> 0 with Z and C
      do_op(1, 2'b00, 32'hFFFF_FFFF, 32'h1, 0, 0);
      check("R2 minus-one-plus-one flags", {27'b0, status_o}, 32'h05);
      // R2: wrapping overflow
      do_op(1, 2'b00, 32'h7FFF_FFFF, 32'h1, 0, 0);
      check("R2 wrap", result_o, 32'h8000_0000);
      // R9: sticky holds after a non-overflow op
      do_op(1, 2'b00, 32'h2, 32'h3, 0, 0);
      check("R9 sticky kept", {27'b0, sticky_o}, 32'h08);
      // R10: clear alone
      do_op(0, 2'b00, 32'h0, 32'h0, 0, 1);
      check("R10 cleared", {27'b0, sticky_o}, 32'h0);
      // R4: positive and negative clamps
      do_op(1, 2'b00, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1, 0);
      check("R4 pos clamp", result_o, 32'h7FFF_FFFF);
      do_op(1, 2'b01, 32'h8000_0000, 32'h1, 1, 0);
      check("R4 neg clamp", result_o, 32'h8000_0000);
      // R10: clear coinciding with overflow keeps overflow bit
      do_op(1, 2'b00, 32'h8000_0000, 32'hFFFF_FFFF, 1, 1);
      check("R10 clear with overflow", {27'b0, sticky_o}, 32'h08);
      // R3: borrow
      do_op(1, 2'b01, 32'h1, 32'h2, 0, 0);
      check("R3 borrow carry", {31'b0, status_o[2]}, 32'h0);
      // R5: averages
      do_op(1, 2'b10, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1, 0);
      check("R5 avg max", result_o, 32'h7FFF_FFFF);
      do_op(1, 2'b10, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 0, 0);
      check("R5 avg floor", result_o, 32'hFFFF_FFFE);
      // R6: compare keeps result
      do_op(1, 2'b11, 32'h5, 32'h5, 0, 0);
      check("R6 cmp result", result_o, 32'hFFFF_FFFE);
      // R8: idle
      do_op(0, 2'b00, 32'h1234, 32'h1, 0, 0);

      for (int i = 0; i < 600; i++) begin
         do_op(($urandom_range(0, 9) != 0), 2'($urandom_range(0, 3)), pick(), pick(),
               1'($urandom_range(0, 1)), ($urandom_range(0, 9) == 0));
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule